// File: doc/BRIEF.md
# Machine-Cycle Clock Rate Controller

This block produces the machine-cycle enable strobe for a fast 8-bit microcontroller core. Every timer, baud-rate divider and sequencer in the core advances only on this strobe. The strobe therefore sets the speed of the whole core. The number of reference clocks per machine cycle is 1, 2, 4 or 1024. The reference clock stands for the already-multiplied oscillator, so the two frequency-multiplier settings appear here only as shorter strobe periods.

Software writes a 2-bit divide field and a multiplier-select bit through a one-clock write port. A new rate does not take effect at once. The machine cycle in which the write lands finishes at the old rate, and so does the machine cycle after it. The new rate starts with the second machine-cycle boundary after the write. One code value is reserved, and writes that carry it are dropped. A wake request makes the core leave the very slow 1024-clock mode and return to the 4-clock rate, with the same delay as a write.

Top module: `mcr_top`

## Requirements
- R1: After reset, `mode_code` is 2'b10 (4 clocks per machine cycle) and `mc_stb` is low. The first strobe is high during the 4th clock after reset is released.
- R2: A write with `cfg_div`=2'b10 selects 4 clocks per machine cycle, whatever the value of `cfg_mul`. The strobe is then high on one clock in every 4.
- R3: A write with `cfg_div`=2'b00 and `cfg_mul`=0 selects 2 clocks per machine cycle. `mode_code` becomes 2'b01.
- R4: A write with `cfg_div`=2'b00 and `cfg_mul`=1 selects 1 clock per machine cycle, so the strobe is high on every clock. `mode_code` becomes 2'b00.
- R5: A write with `cfg_div`=2'b11 selects 1024 clocks per machine cycle. `mode_code` becomes 2'b11.
- R6: A write with `cfg_div`=2'b01 is ignored. The rate and `mode_code` stay unchanged, and a setting already scheduled still takes effect as scheduled.
- R7: A write accepted during machine cycle k (the strobe clock is the last clock of its machine cycle) takes effect at the start of machine cycle k+2. Machine cycles k and k+1 both run at the old rate, and `mode_code` changes in the clock right after the strobe that ends machine cycle k+1.
- R8: When several accepted writes fall in the same machine cycle, only the last one takes effect.
- R9: A `wake_req` while `mode_code` is 2'b11 schedules the 4-clock rate with the R7 timing and takes priority over a write in the same clock. In any other mode, `wake_req` has no effect.
- R10: The strobe is high for exactly one clock per machine cycle, except in the 1-clock mode. At every rate change, the first machine cycle at the new rate has its full length, with no short or doubled pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (the multiplied oscillator) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | One-clock write strobe for the rate control bits |
| cfg_div | input | 2 | Clock-divide field |
| cfg_mul | input | 1 | Multiplier select; used only when `cfg_div` is 2'b00 |
| wake_req | input | 1 | Request to leave the 1024-clock mode |
| mc_stb | output | 1 | Machine-cycle enable, high for one clock per machine cycle |
| mode_code | output | 2 | Active rate: 00=1, 01=2, 10=4, 11=1024 clocks per machine cycle |

## Verification
The assertions check the following on every cycle. `mode_code` only moves on the clock after a strobe. An armed setting is the one that becomes active. A reserved write leaves the scheduled state alone. A wake in the slow mode always leaves the 4-clock rate queued. Outside the 1-clock mode, the strobe never stays high for two clocks in a row. Other properties can only be shown by the bench's scenarios, where a reference model counts machine cycles as integers. These are the exact two-machine-cycle latency, last-write-wins within one machine cycle, writes that land on the strobe clock itself, and full 1024-clock periods around a wake.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [1:0] {
    MC_X4   = 2'b00,
    MC_X2   = 2'b01,
    MC_DIV  = 2'b10,
    MC_SLOW = 2'b11
  } mc_mode_t;

  // Field pair -> active mode; reserved code reports legal = 0
  function automatic logic field_legal(input logic [1:0] div);
    return div != 2'b01;
  endfunction

  function automatic mc_mode_t fields_to_mode(input logic [1:0] div, input logic mul);
    mc_mode_t m;
    case (div)
      2'b00:   m = mul ? MC_X4 : MC_X2;
      2'b11:   m = MC_SLOW;
      default: m = MC_DIV;
    endcase
    return m;
  endfunction

  // Clocks per machine cycle for a mode
  function automatic int unsigned mc_len(input mc_mode_t m, input int unsigned slow_clks);
    int unsigned n;
    case (m)
      MC_X4:   n = 1;
      MC_X2:   n = 2;
      MC_DIV:  n = 4;
      default: n = slow_clks;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mcr_sched.sv
module mcr_sched
  import mcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_div,
  input  logic       cfg_mul,
  input  logic       wake_req,
  input  logic       mc_stb,
  output mc_mode_t   cur_mode,
  output logic       pend_v,
  output mc_mode_t   pend_mode,
  output logic       arm_v,
  output mc_mode_t   arm_mode
);

  logic     wr_ok;
  logic     wake_hit;
  logic     in_v;
  mc_mode_t in_mode;

  assign wr_ok    = cfg_we && field_legal(cfg_div);
  assign wake_hit = wake_req && (cur_mode == MC_SLOW);
  assign in_v     = wr_ok || wake_hit;
  assign in_mode  = wake_hit ? MC_DIV : fields_to_mode(cfg_div, cfg_mul);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode  <= MC_DIV;
      pend_v    <= 1'b0;
      pend_mode <= MC_DIV;
      arm_v     <= 1'b0;
      arm_mode  <= MC_DIV;
    end else if (mc_stb) begin
      if (arm_v) cur_mode <= arm_mode;
      arm_v     <= in_v || pend_v;
      arm_mode  <= in_v ? in_mode : pend_mode;
      pend_v    <= 1'b0;
    end else if (in_v) begin
      pend_v    <= 1'b1;
      pend_mode <= in_mode;
    end
  end

  AST_ARM_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb && arm_v |=> cur_mode == $past(arm_mode)); // R7

  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_stb |=> $stable(cur_mode)); // R7

  AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_div == 2'b01 && !wake_hit && !mc_stb
      |=> pend_v == $past(pend_v) && pend_mode == $past(pend_mode)); // R6

  AST_WAKE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req && cur_mode == MC_SLOW
      |=> (pend_v && pend_mode == MC_DIV) || (arm_v && arm_mode == MC_DIV)); // R9

endmodule

// File: rtl/mcr_pacer.sv
module mcr_pacer
  import mcr_pkg::*;
#(
  parameter int unsigned SLOW_CLKS = 1024,
  localparam int unsigned CNT_W    = $clog2(SLOW_CLKS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  mc_mode_t         mode,
  output logic             mc_stb,
  output logic [CNT_W-1:0] phase
);

  logic [CNT_W-1:0] last_phase;

  assign last_phase = CNT_W'(mc_len(mode, SLOW_CLKS) - 1);
  assign mc_stb     = (phase == last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (mc_stb)  phase <= '0;
    else              phase <= phase + 1'b1;
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb && mode != MC_X4 |=> !mc_stb || mode == MC_X4); // R10

  AST_MODE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(mc_stb)); // R10

endmodule

// File: rtl/mcr_top.sv
module mcr_top
  import mcr_pkg::*;
#(
  parameter int unsigned SLOW_CLKS = 1024
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_div,
  input  logic       cfg_mul,
  input  logic       wake_req,
  output logic       mc_stb,
  output logic [1:0] mode_code
);

  localparam int unsigned CNT_W = $clog2(SLOW_CLKS);

  mc_mode_t         cur_mode;
  logic             pend_v;
  mc_mode_t         pend_mode;
  logic             arm_v;
  mc_mode_t         arm_mode;
  logic [CNT_W-1:0] phase;

  mcr_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_div   (cfg_div),
    .cfg_mul   (cfg_mul),
    .wake_req  (wake_req),
    .mc_stb    (mc_stb),
    .cur_mode  (cur_mode),
    .pend_v    (pend_v),
    .pend_mode (pend_mode),
    .arm_v     (arm_v),
    .arm_mode  (arm_mode)
  );

  mcr_pacer #(.SLOW_CLKS(SLOW_CLKS)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (cur_mode),
    .mc_stb (mc_stb),
    .phase  (phase)
  );

  assign mode_code = cur_mode;

  AST_RESET_RATE: assert property (@(posedge clk)
    !rst_n |=> mode_code == 2'b10 && phase == '0); // R1

endmodule

// File: tb/mcr_top_tb.sv
`timescale 1ns/1ps
module mcr_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_div = 2'b10;
  logic       cfg_mul = 1'b0;
  logic       wake_req = 1'b0;
  logic       mc_stb;
  logic [1:0] mode_code;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;
  string cur_req = "R1";

  // Reference model: rate code, position in the machine cycle, machine-cycle index,
  // and a map from target machine-cycle index to the rate that starts there.
  int m_code;
  int m_pos;
  int m_mc;
  int sched[int];

  always #2.5 clk = ~clk;

  mcr_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_mul(cfg_mul), .wake_req(wake_req), .mc_stb(mc_stb), .mode_code(mode_code)
  );

  function automatic int clocks_of(int code);
    if (code == 0) return 1;
    if (code == 1) return 2;
    if (code == 2) return 4;
    return 1024;
  endfunction

  function automatic int code_of(logic [1:0] d, logic m);
    if (d == 2'b11) return 3;
    if (d == 2'b10) return 2;
    return m ? 0 : 1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_code = 2; m_pos = 0; m_mc = 0;
    sched.delete();
  endtask

  // One clock: called at a falling edge, returns at the next falling edge
  task automatic tick(input logic we, input logic [1:0] d, input logic m, input logic wk);
    bit exp_stb;
    cfg_we = we; cfg_div = d; cfg_mul = m; wake_req = wk;
    exp_stb = (m_pos == clocks_of(m_code) - 1);
    n_vec++;
    if (mc_stb !== exp_stb || int'(mode_code) != m_code) begin
      n_miss++;
      $display("FAIL %s at %0t: actual stb=%0b mode=%0d expected stb=%0b mode=%0d",
               cur_req, $time, mc_stb, mode_code, exp_stb, m_code);
    end
    if (wk && m_code == 3)   sched[m_mc + 2] = 2;
    else if (we && d != 2'b01) sched[m_mc + 2] = code_of(d, m);
    if (exp_stb) begin
      m_mc++;
      m_pos = 0;
      if (sched.exists(m_mc)) begin
        m_code = sched[m_mc];
        sched.delete(m_mc);
      end
    end else begin
      m_pos++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'b10, 1'b0, 1'b0);
  endtask

  task automatic wr(logic [1:0] d, logic m);
    tick(1'b1, d, m, 1'b0);
  endtask

  task automatic to_pos(int p);
    while (m_pos != p) tick(1'b0, 2'b10, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    check("R1 reset mode", int'(mode_code), 2);
    check("R1 reset strobe", int'(mc_stb), 0);
    idle(3);
    check("R1 first strobe", int'(mc_stb), 1);
    cur_req = "R2"; idle(9);

    cur_req = "R3"; wr(2'b00, 1'b0); idle(20);
    check("R3 mode", int'(mode_code), 1);

    cur_req = "R4"; wr(2'b00, 1'b1); idle(10);
    check("R4 mode", int'(mode_code), 0);

    cur_req = "R6"; wr(2'b01, 1'b0); idle(10);
    check("R6 reserved ignored", int'(mode_code), 0);

    cur_req = "R2"; wr(2'b10, 1'b1); idle(12);
    check("R2 mul ignored", int'(mode_code), 2);

    cur_req = "R8"; to_pos(0); wr(2'b11, 1'b0); wr(2'b00, 1'b0); idle(20);
    check("R8 last write wins", int'(mode_code), 1);

    cur_req = "R7"; wr(2'b10, 1'b0); wr(2'b01, 1'b1); idle(3);
    cur_req = "R10"; to_pos(clocks_of(m_code) - 1); wr(2'b00, 1'b1); idle(6);
    cur_req = "R7"; to_pos(0); wr(2'b10, 1'b0); idle(20);
    check("R7 back to four", int'(mode_code), 2);
    cur_req = "R10"; to_pos(3); wr(2'b00, 1'b0); idle(14);

    cur_req = "R5"; wr(2'b11, 1'b0); idle(2100);
    check("R5 slow mode", int'(mode_code), 3);

    cur_req = "R9"; to_pos(100); tick(1'b0, 2'b10, 1'b0, 1'b1); idle(2200);
    check("R9 wake to four", int'(mode_code), 2);
    tick(1'b0, 2'b10, 1'b0, 1'b1); idle(20);
    check("R9 wake ignored", int'(mode_code), 2);

    cur_req = "R5"; wr(2'b11, 1'b0); idle(12);
    cur_req = "R9"; to_pos(1023); tick(1'b1, 2'b00, 1'b1, 1'b1); idle(1100);
    check("R9 wake over write", int'(mode_code), 2);
    cur_req = "R6"; wr(2'b01, 1'b0); idle(12);
    check("R6 reserved in four", int'(mode_code), 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule